// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Scanner

This block drives a four-digit, common-anode seven-segment display in which all digits share one set of segment lines. It takes four 4-bit hexadecimal digit values and time-multiplexes them onto the display. At any moment exactly one digit's anode is enabled, and that digit's segment pattern is on the shared segment lines.

A free-running refresh counter of `REFRESH_BITS` bits advances on every clock. Its top two bits choose the digit being shown. Each digit therefore stays lit for 2^(REFRESH_BITS-2) clocks, and the four digits are visited in order 0, 1, 2, 3 before the sequence repeats. With a 100 MHz clock and the default of 18 bits, each digit refreshes at roughly 380 Hz, which is fast enough that all four digits appear lit at once. The anode and segment outputs are registered together, so they always change on the same clock edge.

Top module: `seg7_scan_top`

## Requirements
- R1: An active-low asynchronous reset (`rstN` low) immediately drives `anodeN` to 4'b1111 and `segN` to 7'b1111111 and clears the refresh counter. At the first clock edge after release the outputs show digit 0.
- R2: The refresh counter increments on every clock and wraps at 2^REFRESH_BITS. The digit select is the counter's two most significant bits, so each digit is shown for 2^(REFRESH_BITS-2) consecutive edges, in the order 0, 1, 2, 3, 0.
- R3: `anodeN` is one-hot active low. Select 0 gives 4'b1110, select 1 gives 4'b1101, select 2 gives 4'b1011 and select 3 gives 4'b0111. Outside reset, no more than one anode is low.
- R4: Select value k routes input `digitk` (k = 0..3) to the segment decoder.
- R5: Segments are active low, with bit 0 = A, 1 = B, 2 = C, 3 = D, 4 = E, 5 = F and 6 = G. Written G down to A, the patterns for 0..F are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000, 0001000, 0000011, 1000110, 0100001, 0000110 and 0001110.
- R6: Both output vectors are registered and update on the same edge. The value seen after edge t reflects the counter value held before edge t and the digit inputs present at edge t.
- R7: `dpN`, the decimal point, is held at 1 (off) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| digit0 | input | 4 | Hex value for digit 0 |
| digit1 | input | 4 | Hex value for digit 1 |
| digit2 | input | 4 | Hex value for digit 2 |
| digit3 | input | 4 | Hex value for digit 3 |
| anodeN | output | 4 | Digit enables, active low, one-hot |
| segN | output | 7 | Segments G..A in bits 6..0, active low |
| dpN | output | 1 | Decimal point, always off (1) |

## Verification
The bench runs the design with a 4-bit refresh counter so that a whole scan takes 16 cycles. Every hex value is swept through every digit position, and the digit inputs are also changed in the middle of a dwell. The corner cases it targets are:
- the one-cycle output latency, which a design with a combinational path or an extra register would get wrong by showing the wrong dwell boundaries;
- a swapped digit route or anode order, which would light the right pattern on the wrong digit;
- a wrong entry in the decoder, or a reversed segment order;
- a reset that is only synchronous, which would leave a digit lit while the reset is held between clock edges.

// File: rtl/seg7_scan_pkg.sv
package seg7_scan_pkg;
  localparam int DIGIT_COUNT = 4;
  localparam int NIBBLE_W    = 4;
  localparam int SEG_W       = 7;
  localparam int SEL_W       = $clog2(DIGIT_COUNT);

  typedef struct packed {
    logic [SEL_W-1:0]       digitSel;
    logic [DIGIT_COUNT-1:0] anodeHot;
  } scanStrobe_t;

  // Active-low pattern, bit 6 = G .. bit 0 = A
  function automatic logic [SEG_W-1:0] hexToSegN(input logic [NIBBLE_W-1:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'h0: p = 7'b1000000;
      4'h1: p = 7'b1111001;
      4'h2: p = 7'b0100100;
      4'h3: p = 7'b0110000;
      4'h4: p = 7'b0011001;
      4'h5: p = 7'b0010010;
      4'h6: p = 7'b0000010;
      4'h7: p = 7'b1111000;
      4'h8: p = 7'b0000000;
      4'h9: p = 7'b0010000;
      4'hA: p = 7'b0001000;
      4'hB: p = 7'b0000011;
      4'hC: p = 7'b1000110;
      4'hD: p = 7'b0100001;
      4'hE: p = 7'b0000110;
      default: p = 7'b0001110;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/seg7_scan_ctrl.sv
module seg7_scan_ctrl
  import seg7_scan_pkg::*;
#(
  parameter int REFRESH_BITS = 18
) (
  input  logic        clk,
  input  logic        rstN,
  output scanStrobe_t strobe
);
  logic [REFRESH_BITS-1:0] refreshCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refreshCnt <= '0;
    else       refreshCnt <= refreshCnt + 1'b1;
  end

  assign strobe.digitSel = refreshCnt[REFRESH_BITS-1 -: SEL_W];

  for (genvar k = 0; k < DIGIT_COUNT; k++) begin : g_hot
    assign strobe.anodeHot[k] = (strobe.digitSel == SEL_W'(k));
  end
endmodule

// File: rtl/seg7_scan_dp.sv
module seg7_scan_dp
  import seg7_scan_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  scanStrobe_t                          strobe,
  input  logic [DIGIT_COUNT-1:0][NIBBLE_W-1:0] digitBus,
  output logic [DIGIT_COUNT-1:0]               anodeN,
  output logic [SEG_W-1:0]                     segN
);
  logic [NIBBLE_W-1:0] pickedNibble;

  assign pickedNibble = digitBus[strobe.digitSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anodeN <= '1;
      segN   <= '1;
    end else begin
      anodeN <= ~strobe.anodeHot;
      segN   <= hexToSegN(pickedNibble);
    end
  end
endmodule

// File: rtl/seg7_scan_top.sv
module seg7_scan_top #(
  parameter int REFRESH_BITS = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] digit0,
  input  logic [3:0] digit1,
  input  logic [3:0] digit2,
  input  logic [3:0] digit3,
  output logic [3:0] anodeN,
  output logic [6:0] segN,
  output logic       dpN
);
  import seg7_scan_pkg::*;

  scanStrobe_t                          strobe;
  logic [DIGIT_COUNT-1:0][NIBBLE_W-1:0] digitBus;

  assign digitBus = {digit3, digit2, digit1, digit0};
  assign dpN      = 1'b1;

  seg7_scan_ctrl #(.REFRESH_BITS(REFRESH_BITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  seg7_scan_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .digitBus (digitBus),
    .anodeN   (anodeN),
    .segN     (segN)
  );
endmodule

// File: rtl/seg7_scan_checker.sv
module seg7_scan_checker #(
  parameter int REFRESH_BITS = 18
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] digit0,
  input logic [3:0] digit1,
  input logic [3:0] digit2,
  input logic [3:0] digit3,
  input logic [3:0] anodeN,
  input logic [6:0] segN
);
  localparam int DWELL = 1 << (REFRESH_BITS - 2);

  logic [3:0]              lastAn;
  logic [REFRESH_BITS-1:0] runLen;
  logic [15:0]             digitsNow;

  assign digitsNow = {digit3, digit2, digit1, digit0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAn <= 4'hF;
      runLen <= '0;
    end else begin
      lastAn <= anodeN;
      runLen <= (anodeN != lastAn) ? REFRESH_BITS'(1) : runLen + 1'b1;
    end
  end

  AST_ANODE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~anodeN)) else $error("anode not one-hot");  // R3

  AST_BLANK_SEGS: assert property (@(posedge clk) disable iff (!rstN)
    (anodeN == 4'hF) |-> (segN == 7'h7F)) else $error("blank mismatch");  // R1

  AST_FIRST_DIGIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(anodeN) == 4'hF && anodeN != 4'hF) |-> (anodeN == 4'b1110)) else $error("scan start");  // R1

  AST_ROTATE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (anodeN != $past(anodeN) && $past(anodeN) != 4'hF)
      |-> (anodeN == {$past(anodeN[2:0]), $past(anodeN[3])})) else $error("order");  // R2

  AST_DWELL_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (anodeN != lastAn && lastAn != 4'hF) |-> (runLen == REFRESH_BITS'(DWELL))) else $error("dwell");  // R2

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (anodeN != 4'hF && $stable(anodeN) && $past(digitsNow) == $past(digitsNow, 2))
      |-> $stable(segN)) else $error("seg hold");  // R6
endmodule

bind seg7_scan_top seg7_scan_checker #(.REFRESH_BITS(REFRESH_BITS)) u_checker (
  .clk(clk), .rstN(rstN), .digit0(digit0), .digit1(digit1),
  .digit2(digit2), .digit3(digit3), .anodeN(anodeN), .segN(segN)
);

// File: tb/seg7_scan_top_tb.sv
module seg7_scan_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int SCAN       = 1 << NB;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] digit0 = 0, digit1 = 0, digit2 = 0, digit3 = 0;
  logic [3:0] anodeN;
  logic [6:0] segN;
  logic       dpN;

  int compared = 0;
  int mismatched = 0;
  int edgeCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg7_scan_top #(.REFRESH_BITS(NB)) u_dut (
    .clk(clk), .rstN(rstN), .digit0(digit0), .digit1(digit1),
    .digit2(digit2), .digit3(digit3), .anodeN(anodeN), .segN(segN), .dpN(dpN)
  );

  // Active-high lit set per value, bit0 = A .. bit6 = G
  function automatic logic [6:0] litSet(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      int sel;
      logic [3:0] nib;
      logic [3:0] expAn;
      logic [6:0] expSeg;
      @(posedge clk);
      edgeCnt++;
      sel = (((edgeCnt - 1) % SCAN) >> (NB - 2)) & 3;
      nib = (sel == 0) ? digit0 : (sel == 1) ? digit1 : (sel == 2) ? digit2 : digit3;
      expAn  = ~(4'b0001 << sel);
      expSeg = ~litSet(nib);
      @(negedge clk);
      check(anodeN == expAn, "R2/R3 anode", anodeN, expAn);
      check(segN == expSeg, "R4/R5/R6 seg", segN, expSeg);
      check(dpN == 1'b1, "R7 dp", dpN, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    check(anodeN == 4'hF, "R1 reset anode", anodeN, 4'hF);
    check(segN == 7'h7F, "R1 reset seg", segN, 7'h7F);
    check(dpN == 1'b1, "R7 dp in reset", dpN, 1);
    @(negedge clk);
    rstN = 1'b1;
    // R4 R5 sweep: every value through every digit position
    for (int v = 0; v < 16; v++) begin
      digit0 = 4'(v); digit1 = 4'(v + 5); digit2 = 4'(v + 10); digit3 = 4'(v + 15);
      runCycles(SCAN);
    end
    // R6: inputs change mid-dwell, picked up at the next edge
    for (int j = 0; j < 12; j++) begin
      digit0 = 4'(j * 3); digit1 = 4'(j * 7 + 1); digit2 = 4'(j * 5 + 2); digit3 = 4'(j * 11 + 3);
      runCycles(3);
    end
    // R1: asynchronous reset between edges
    #2;
    rstN = 1'b0;
    #1;
    check(anodeN == 4'hF, "R1 async anode", anodeN, 4'hF);
    check(segN == 7'h7F, "R1 async seg", segN, 7'h7F);
    @(negedge clk);
    @(negedge clk);
    check(anodeN == 4'hF, "R1 held anode", anodeN, 4'hF);
    rstN = 1'b1;
    edgeCnt = 0;
    digit0 = 4'hA; digit1 = 4'hB; digit2 = 4'hC; digit3 = 4'hD;
    runCycles(2 * SCAN + 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule